// File: doc/BRIEF.md
# Two-Port Burst SRAM Core with Write Forwarding

This block is a synchronous memory core. It has a read port and a write port with separate data paths, and both ports share one address input. Each address holds a pair of data words. A write moves the pair in as two beats, and a read returns the pair as two beats. The block runs from a single clock `clk`, and every rising edge of `clk` is one phase. After reset the first rising edge is a "rise" phase. Rise and "fall" phases then alternate, so two edges make one access cycle. The port selects and the read address are sampled on rise edges. The write address is sampled on fall edges.

Writes complete internally with no further control. Each data beat is split into 9-bit lanes, and an active-low lane mask protects each lane. A read always returns the most recent data. A read issued in the cycle right after a write to the same address sees that write. A read issued in the same cycle as a write to the same address also sees it. Write data that has not yet reached the array is merged into the read result, lane by lane, under that write's masks. When no read beat is being delivered, the output is zero and its valid flag is low.

Top module: `qbs_core`

## Requirements
- R1: While reset is held, and after it is released, `rd_qv` is 0 and `rd_q` is 0. Every word of the array reads back as 0 after reset. The first rising edge after reset is a rise phase, and the phases then alternate.
- R2: If `rd_sel_n` is 0 at a rise edge e, word 0 of the addressed pair appears on `rd_q` with `rd_qv`=1 after edge e+3. Word 1 follows after edge e+4. Reads issued in consecutive cycles stream with no gap.
- R3: If `wr_sel_n` is 0 at a rise edge e, the write address and beat 0 (`wr_d`, `wr_be_n`) are taken at edge e+1. Beat 1 is taken at edge e+2. Later reads of that address return beat 0 as word 0 and beat 1 as word 1.
- R4: Lane i is bits 9*i+8 down to 9*i of a beat. A lane is written only when bit i of `wr_be_n` is 0 at that beat's edge. A lane whose bit is 1 keeps its old contents.
- R5: `rd_sel_n` and `wr_sel_n` are ignored at fall edges. A select that is 1 at a rise edge causes no read output and no array change.
- R6: The read address is taken from `addr` only at the rise edge. The write address is taken from `addr` only at the following fall edge, so one cycle can read one address and write another.
- R7: A read issued in the cycle after a write to the same address returns the new data.
- R8: A read and a write to the same address issued in the same cycle return the newly written lanes, merged with the older contents of the lanes that were not written.
- R9: At every edge where no read beat is due, `rd_qv` is 0 and `rd_q` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock; each rising edge is one half of an access cycle |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Shared address: read address at rise edges, write address at fall edges |
| rd_sel_n | input | 1 | Active-low read select, sampled at rise edges |
| wr_sel_n | input | 1 | Active-low write select, sampled at rise edges |
| wr_d | input | LANES*9 | Write data beat |
| wr_be_n | input | LANES | Active-low lane write masks for the current beat |
| rd_q | output | LANES*9 | Read data beat |
| rd_qv | output | 1 | High while `rd_q` carries a read beat |

## Verification
The functions that can fall in the same cycle are a read lookup and a write that has not yet been committed to the array. There are two cases: a write issued in the same cycle as the read, and a write issued in the cycle before it. The bench provokes both by issuing a write and then a read of the same address in one cycle, and in adjacent cycles, with partial lane masks over known older contents. It judges the returned words against a reference memory that applies each write in issue order before computing the read result. A fault in the lane-by-lane merge therefore shows up in one lane only.

// File: rtl/qbs_pkg.sv
package qbs_pkg;

    localparam int LANE_W = 9;

    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } phase_e;

    function automatic logic sel_taken(input logic sel_n, input phase_e ph);
        return (!sel_n) && (ph == PH_RISE);
    endfunction

endpackage

// File: rtl/qbs_lane_merge.sv
module qbs_lane_merge
    import qbs_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [LANES*LANE_W-1:0] old_d,
    input  logic [LANES*LANE_W-1:0] new_d,
    input  logic [LANES-1:0]        keep_n,
    output logic [LANES*LANE_W-1:0] out_d
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign out_d[i*LANE_W +: LANE_W] = keep_n[i] ? old_d[i*LANE_W +: LANE_W]
                                                     : new_d[i*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/qbs_wr_path.sv
module qbs_wr_path
    import qbs_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  phase_e                  ph,
    input  logic [AW-1:0]           addr,
    input  logic                    wr_sel_n,
    input  logic [LANES*LANE_W-1:0] wr_d,
    input  logic [LANES-1:0]        wr_be_n,
    output logic                    pend_v,
    output logic [AW-1:0]           pend_a,
    output logic [LANES*LANE_W-1:0] pend_d0,
    output logic [LANES*LANE_W-1:0] pend_d1,
    output logic [LANES-1:0]        pend_m0,
    output logic [LANES-1:0]        pend_m1,
    output logic                    commit
);

    localparam int DW = LANES * LANE_W;

    logic          wreq;
    logic          cap_v;
    logic [AW-1:0] cap_a;
    logic [DW-1:0] cap_d;
    logic [LANES-1:0] cap_m;
    logic          fresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            wreq    <= 1'b0;
            cap_v   <= 1'b0;
            cap_a   <= '0;
            cap_d   <= '0;
            cap_m   <= '1;
            pend_v  <= 1'b0;
            pend_a  <= '0;
            pend_d0 <= '0;
            pend_d1 <= '0;
            pend_m0 <= '1;
            pend_m1 <= '1;
            fresh   <= 1'b0;
        end else begin
            fresh <= 1'b0;
            if (ph == PH_RISE) begin
                wreq  <= sel_taken(wr_sel_n, ph);
                cap_v <= 1'b0;
                if (cap_v) begin
                    pend_v  <= 1'b1;
                    pend_a  <= cap_a;
                    pend_d0 <= cap_d;
                    pend_m0 <= cap_m;
                    pend_d1 <= wr_d;
                    pend_m1 <= wr_be_n;
                    fresh   <= 1'b1;
                end
            end else begin
                wreq <= 1'b0;
                if (wreq) begin
                    cap_v <= 1'b1;
                    cap_a <= addr;
                    cap_d <= wr_d;
                    cap_m <= wr_be_n;
                end
            end
        end
    end

    assign commit = fresh;

endmodule

// File: rtl/qbs_array.sv
module qbs_array
    import qbs_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [AW-1:0]           wa,
    input  logic [LANES*LANE_W-1:0] wd0,
    input  logic [LANES*LANE_W-1:0] wd1,
    input  logic [LANES-1:0]        wm0,
    input  logic [LANES-1:0]        wm1,
    input  logic [AW-1:0]           ra,
    input  logic                    rb,
    output logic [LANES*LANE_W-1:0] rq
);

    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH][2];
    logic [DW-1:0] nxt [2];
    logic [DW-1:0] wdat [2];
    logic [LANES-1:0] wmsk [2];

    assign wdat[0] = wd0;
    assign wdat[1] = wd1;
    assign wmsk[0] = wm0;
    assign wmsk[1] = wm1;

    for (genvar b = 0; b < 2; b++) begin : g_beat
        qbs_lane_merge #(.LANES(LANES)) u_mrg (
            .old_d  (mem[wa][b]),
            .new_d  (wdat[b]),
            .keep_n (wmsk[b]),
            .out_d  (nxt[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i][0] <= '0;
                mem[i][1] <= '0;
            end
        end else if (we) begin
            mem[wa][0] <= nxt[0];
            mem[wa][1] <= nxt[1];
        end
    end

    assign rq = mem[ra][rb];

endmodule

// File: rtl/qbs_rd_path.sv
module qbs_rd_path
    import qbs_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  phase_e                  ph,
    input  logic [AW-1:0]           addr,
    input  logic                    rd_sel_n,
    output logic [AW-1:0]           arr_a,
    output logic                    arr_b,
    input  logic [LANES*LANE_W-1:0] arr_q,
    input  logic                    pend_v,
    input  logic [AW-1:0]           pend_a,
    input  logic [LANES*LANE_W-1:0] pend_d0,
    input  logic [LANES*LANE_W-1:0] pend_d1,
    input  logic [LANES-1:0]        pend_m0,
    input  logic [LANES-1:0]        pend_m1,
    output logic [LANES*LANE_W-1:0] rd_q,
    output logic                    rd_qv
);

    localparam int DW     = LANES * LANE_W;
    localparam int STAGES = 4;

    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
    } stage_t;

    stage_t st [STAGES];

    logic             beat_due;
    logic             hit;
    logic [DW-1:0]    fwd_d;
    logic [LANES-1:0] fwd_m;
    logic [DW-1:0]    merged;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0].v <= sel_taken(rd_sel_n, ph);
            st[0].a <= addr;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign beat_due = st[2].v || st[3].v;
    assign arr_b    = !st[2].v;
    assign arr_a    = st[2].v ? st[2].a : st[3].a;
    assign hit      = pend_v && (pend_a == arr_a);
    assign fwd_d    = arr_b ? pend_d1 : pend_d0;
    assign fwd_m    = hit ? (arr_b ? pend_m1 : pend_m0) : '1;

    qbs_lane_merge #(.LANES(LANES)) u_fwd (
        .old_d  (arr_q),
        .new_d  (fwd_d),
        .keep_n (fwd_m),
        .out_d  (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            rd_qv <= 1'b0;
        end else begin
            rd_qv <= beat_due;
            rd_q  <= beat_due ? merged : '0;
        end
    end

endmodule

// File: rtl/qbs_core.sv
module qbs_core
    import qbs_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [AW-1:0]           addr,
    input  logic                    rd_sel_n,
    input  logic                    wr_sel_n,
    input  logic [LANES*LANE_W-1:0] wr_d,
    input  logic [LANES-1:0]        wr_be_n,
    output logic [LANES*LANE_W-1:0] rd_q,
    output logic                    rd_qv
);

    localparam int DW = LANES * LANE_W;

    phase_e           ph;
    logic             pend_v;
    logic [AW-1:0]    pend_a;
    logic [DW-1:0]    pend_d0;
    logic [DW-1:0]    pend_d1;
    logic [LANES-1:0] pend_m0;
    logic [LANES-1:0] pend_m1;
    logic             wr_commit;
    logic [AW-1:0]    arr_a;
    logic             arr_b;
    logic [DW-1:0]    arr_q;

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_RISE;
        else     ph <= (ph == PH_RISE) ? PH_FALL : PH_RISE;
    end

    qbs_wr_path #(.AW(AW), .LANES(LANES)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .ph       (ph),
        .addr     (addr),
        .wr_sel_n (wr_sel_n),
        .wr_d     (wr_d),
        .wr_be_n  (wr_be_n),
        .pend_v   (pend_v),
        .pend_a   (pend_a),
        .pend_d0  (pend_d0),
        .pend_d1  (pend_d1),
        .pend_m0  (pend_m0),
        .pend_m1  (pend_m1),
        .commit   (wr_commit)
    );

    qbs_array #(.AW(AW), .LANES(LANES)) u_arr (
        .clk (clk),
        .rst (rst),
        .we  (wr_commit),
        .wa  (pend_a),
        .wd0 (pend_d0),
        .wd1 (pend_d1),
        .wm0 (pend_m0),
        .wm1 (pend_m1),
        .ra  (arr_a),
        .rb  (arr_b),
        .rq  (arr_q)
    );

    qbs_rd_path #(.AW(AW), .LANES(LANES)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .ph       (ph),
        .addr     (addr),
        .rd_sel_n (rd_sel_n),
        .arr_a    (arr_a),
        .arr_b    (arr_b),
        .arr_q    (arr_q),
        .pend_v   (pend_v),
        .pend_a   (pend_a),
        .pend_d0  (pend_d0),
        .pend_d1  (pend_d1),
        .pend_m0  (pend_m0),
        .pend_m1  (pend_m1),
        .rd_q     (rd_q),
        .rd_qv    (rd_qv)
    );

endmodule

// File: rtl/qbs_chk.sv
module qbs_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_sel_n,
    input logic          wr_sel_n,
    input logic [DW-1:0] rd_q,
    input logic          rd_qv,
    input logic          wr_commit
);

    logic cph;
    logic r_iss;
    logic w_iss;

    always_ff @(posedge clk) begin
        if (rst) cph <= 1'b0;
        else     cph <= !cph;
    end

    assign r_iss = !rst && !cph && !rd_sel_n;
    assign w_iss = !rst && !cph && !wr_sel_n;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_qv |-> (rd_q == '0)); // R9

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_qv == ($past(r_iss, 4) || $past(r_iss, 5))); // R2

    AST_BEAT_PAIR: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_qv) |=> rd_qv); // R2

    AST_WRITE_SELECT: assert property (@(posedge clk) disable iff (rst)
        wr_commit == $past(w_iss, 3)); // R5

endmodule

bind qbs_core qbs_chk #(.DW(LANES*qbs_pkg::LANE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_sel_n  (rd_sel_n),
    .wr_sel_n  (wr_sel_n),
    .rd_q      (rd_q),
    .rd_qv     (rd_qv),
    .wr_commit (wr_commit)
);

// File: tb/sim_qbs_core.sv
`timescale 1ns/1ps
module sim_qbs_core;

    localparam int AW    = 4;
    localparam int LANES = 2;
    localparam int DW    = LANES * 9;
    localparam int NEXP  = 4096;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [AW-1:0]    addr = '0;
    logic             rd_sel_n = 1'b1;
    logic             wr_sel_n = 1'b1;
    logic [DW-1:0]    wr_d = '0;
    logic [LANES-1:0] wr_be_n = '1;
    logic [DW-1:0]    rd_q;
    logic             rd_qv;

    int checks = 0;
    int errors = 0;
    int ec = 0;
    bit done = 0;

    logic [DW-1:0] mdl [1<<AW][2];
    bit            exp_v [NEXP];
    logic [DW-1:0] exp_d [NEXP];
    string         exp_t [NEXP];
    logic [DW-1:0] nx_d = '0;
    logic [LANES-1:0] nx_m = '1;

    qbs_core #(.AW(AW), .LANES(LANES)) u0 (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n),
        .wr_d     (wr_d),
        .wr_be_n  (wr_be_n),
        .rd_q     (rd_q),
        .rd_qv    (rd_qv)
    );

    always #4 clk = ~clk;

    always @(posedge clk) ec <= ec + 1;

    function automatic logic [DW-1:0] lmerge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                             input logic [LANES-1:0] m);
        logic [DW-1:0] r = o;
        for (int i = 0; i < LANES; i++) if (!m[i]) r[i*9 +: 9] = n[i*9 +: 9];
        return r;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv,
                         input logic actv, input logic expvv);
        checks++;
        if (act !== expv || actv !== expvv) begin
            errors++;
            $display("FAIL %s edge %0d: q=%h qv=%b expected q=%h qv=%b", tag, ec, act, actv, expv, expvv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (exp_v[ec % NEXP]) check(exp_t[ec % NEXP], rd_q, exp_d[ec % NEXP], rd_qv, 1'b1);
            else                  check("R9", rd_q, '0, rd_qv, 1'b0);
        end
    end

    // one access cycle: called at a negedge just before a rise edge
    task automatic cyc(input bit rd, input logic [AW-1:0] ra, input bit wr, input logic [AW-1:0] wa,
                       input logic [DW-1:0] d0, input logic [LANES-1:0] m0,
                       input logic [DW-1:0] d1, input logic [LANES-1:0] m1,
                       input bit bad_rd, input bit bad_wr, input string tag);
        int e;
        e = ec + 1;
        rd_sel_n = !rd;
        wr_sel_n = !wr;
        addr     = ra;
        wr_d     = nx_d;
        wr_be_n  = nx_m;
        if (wr) begin
            mdl[wa][0] = lmerge(mdl[wa][0], d0, m0);
            mdl[wa][1] = lmerge(mdl[wa][1], d1, m1);
        end
        if (rd) begin
            exp_v[(e+3) % NEXP] = 1; exp_d[(e+3) % NEXP] = mdl[ra][0]; exp_t[(e+3) % NEXP] = tag;
            exp_v[(e+4) % NEXP] = 1; exp_d[(e+4) % NEXP] = mdl[ra][1]; exp_t[(e+4) % NEXP] = tag;
        end
        @(negedge clk);
        rd_sel_n = !bad_rd;
        wr_sel_n = !bad_wr;
        addr     = wa;
        wr_d     = d0;
        wr_be_n  = m0;
        nx_d     = d1;
        nx_m     = m1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, 18'h3FFFF, '0, 18'h3FFFF, '0, 0, 0, "R9");
    endtask

    task automatic wr_pair(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [LANES-1:0] m0,
                           input logic [DW-1:0] d1, input logic [LANES-1:0] m1);
        cyc(0, '0, 1, a, d0, m0, d1, m1, 0, 0, "R3");
    endtask

    task automatic rd_pair(input logic [AW-1:0] a, input string tag);
        cyc(1, a, 0, '0, '0, '1, '0, '1, 0, 0, tag);
    endtask

    task automatic t_reset;
        check("R1", rd_q, '0, rd_qv, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        rd_pair(4'd0, "R1");
        rd_pair(4'd7, "R1");
        idle(3);
    endtask

    task automatic t_basic;
        wr_pair(4'd5, 18'h1A2B3, 2'b00, 18'h0C4D5, 2'b00);
        wr_pair(4'd9, 18'h3FFFF, 2'b00, 18'h00001, 2'b00);
        idle(2);
        rd_pair(4'd5, "R3");
        rd_pair(4'd9, "R2");
        rd_pair(4'd5, "R2");
        idle(3);
    endtask

    task automatic t_masks;
        wr_pair(4'd3, 18'h2AAAA, 2'b00, 18'h15555, 2'b00);
        wr_pair(4'd3, 18'h00123, 2'b10, 18'h3F000, 2'b01);
        idle(2);
        rd_pair(4'd3, "R4");
        wr_pair(4'd3, 18'h11111, 2'b11, 18'h22222, 2'b11);
        idle(2);
        rd_pair(4'd3, "R4");
        idle(3);
    endtask

    task automatic t_phase;
        cyc(0, 4'd5, 0, 4'd5, 18'h0BEEF, 2'b00, 18'h0CAFE, 2'b00, 1, 1, "R5");
        idle(2);
        rd_pair(4'd5, "R5");
        idle(2);
        cyc(1, 4'd9, 1, 4'd12, 18'h12345, 2'b00, 18'h2468A, 2'b00, 0, 0, "R6");
        idle(2);
        rd_pair(4'd12, "R6");
        rd_pair(4'd9, "R6");
        idle(3);
    endtask

    task automatic t_prev;
        wr_pair(4'd6, 18'h0F0F0, 2'b00, 18'h30303, 2'b00);
        idle(2);
        wr_pair(4'd6, 18'h1DEAD, 2'b01, 18'h2BEEF, 2'b00);
        rd_pair(4'd6, "R7");
        wr_pair(4'd6, 18'h07777, 2'b00, 18'h08888, 2'b10);
        rd_pair(4'd6, "R7");
        idle(3);
    endtask

    task automatic t_same;
        wr_pair(4'd10, 18'h3C3C3, 2'b00, 18'h24924, 2'b00);
        idle(2);
        cyc(1, 4'd10, 1, 4'd10, 18'h11AA1, 2'b10, 18'h01F2E, 2'b01, 0, 0, "R8");
        cyc(1, 4'd10, 1, 4'd10, 18'h3ABCD, 2'b00, 18'h0000F, 2'b00, 0, 0, "R8");
        cyc(1, 4'd10, 0, 4'd0, '0, '1, '0, '1, 0, 0, "R7");
        idle(3);
    endtask

    initial begin
        for (int i = 0; i < (1<<AW); i++) begin mdl[i][0] = '0; mdl[i][1] = '0; end
        for (int i = 0; i < NEXP; i++) begin exp_v[i] = 0; exp_d[i] = '0; exp_t[i] = ""; end
        repeat (4) @(negedge clk);
        t_reset;
        t_basic;
        t_masks;
        t_phase;
        t_prev;
        t_same;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule